// File: doc/BRIEF.md
# Page RAM Auto-Attribute Write Controller

This block sits behind a serial-bus slave front-end and turns the bytes of one write transaction into write cycles on a 512-word display page RAM. The front-end delivers a transaction start pulse once its device address has matched. It then delivers the payload bytes one per valid strobe, and a stop pulse at the end. The first two payload bytes form a 16-bit register address, low byte first. When that address falls in the page RAM window, the next byte is an attribute byte. Its character-code high bit and 4-bit color attribute are merged into every data byte that follows. Each merged 13-bit word is written at an address that advances by one per data byte.

A separate control register sits at register address 0x8400. Writing it with bit 3 set starts a sequential clear that writes zero into every page RAM location, one location per clock. While the clear runs, a busy output is high and data bytes are dropped. An attribute byte that selects any mode other than the plain auto-attribute mode raises an unsupported-mode flag. No page RAM writes happen for the rest of that transaction.

Top module: `pram_autoattr_wr`

## Requirements
- R1: While reset is applied and after its release, `ram_we`, `clr_busy` and `mode_err` are 0 until stimulus arrives.
- R2: After a start, the first accepted byte is the low half and the second is the high half of a 16-bit register address. Page RAM location = register address minus 0x8000.
- R3: The byte after the address pair is the attribute byte when the address is not 0x8400: bits 6:5 = mode, bit 4 = character bit 8, bits 3:0 = attribute. With mode 00, each later data byte D is written as the 13-bit word {bit8, D, attr}: bit 12 = character bit 8, bits 11:4 = D, bits 3:0 = attr.
- R4: Each data byte produces a write with `ram_we` high in the cycle after the byte is accepted. Successive data bytes go to successive locations starting at the transaction's address, and a second byte after the address pair is never taken as an attribute.
- R5: A data byte whose current register address lies outside 0x8000..0x81FF is not written, including bytes that run past 0x81FF. The address still advances by one.
- R6: An attribute byte with mode bits 6:5 not equal to 00 sets `mode_err` in the next cycle. `mode_err` holds until the next start, and no data write occurs in between.
- R7: At register address 0x8400, a byte with bit 3 = 1 raises `clr_busy` in the next cycle. The block then writes zero to locations 0,1,...,511 on 512 consecutive cycles, the first in the cycle after `clr_busy` rises. `clr_busy` is low again in the cycle that shows the write to location 511.
- R8: At register address 0x8400, a byte with bit 3 = 0 starts no clear and writes nothing. Bytes after the control byte in the same transaction are ignored.
- R9: A data byte accepted while `clr_busy` is high is dropped, and the address still advances by one.
- R10: Bytes arriving before the first start, or after a stop, produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_start | input | 1 | Pulse: a new write transaction begins |
| in_stop | input | 1 | Pulse: the transaction ends |
| in_valid | input | 1 | A payload byte is present on in_byte |
| in_byte | input | 8 | Payload byte |
| ram_we | output | 1 | Page RAM write strobe |
| ram_addr | output | 9 | Page RAM location |
| ram_wdata | output | 13 | Word written: {char bit 8, char byte, attr} |
| clr_busy | output | 1 | Whole-RAM clear in progress |
| mode_err | output | 1 | Unsupported attribute mode seen in this transaction |

## Verification
The hardest situation to reach is a data transaction that overlaps a running clear. Some of its bytes must be dropped and the rest written at advanced addresses, and nothing from the port shows which bytes fell inside the busy window. The stimulus triggers a clear and at once opens a long page RAM transaction, so the data stream straddles the falling edge of `clr_busy`. A shadow memory built from the observed write port is then compared, location by location, with the bench's own model, which decides drop or write from the busy level seen when each byte was driven. Random transactions start near the top of the window to cover the address running past 0x81FF, and some use a nonzero mode to cover the unsupported-mode case.

// File: rtl/pram_pkg.sv
package pram_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ADR_LO,
    PS_ADR_HI,
    PS_ATTR,
    PS_DATA,
    PS_CTRL,
    PS_SKIP
  } parse_st_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/pram_hdr_parse.sv
module pram_hdr_parse
  import pram_pkg::*;
#(
  parameter int          ATTR_W    = 4,
  parameter logic [15:0] CTRL_ADDR = 16'h8400,
  parameter int          MODE_LSB  = 5,
  parameter int          CC8_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_start,
  input  logic              in_stop,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              dat_req,
  output logic [15:0]       reg_addr,
  output logic              cc8,
  output logic [ATTR_W-1:0] attr,
  output logic              ctrl_req,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic              mode_err
);

  parse_st_e         st_q, st_n;
  logic [15:0]       addr_q, addr_n;
  logic              addr_ld;
  logic              cc8_q, cc8_n;
  logic [ATTR_W-1:0] attr_q, attr_n;
  logic              attr_ld;
  logic              err_q, err_n;
  logic [15:0]       full_addr;

  assign full_addr = {in_byte, addr_q[7:0]};

  // next-state process
  always_comb begin
    st_n     = st_q;
    addr_n   = addr_q;
    addr_ld  = 1'b0;
    cc8_n    = cc8_q;
    attr_n   = attr_q;
    attr_ld  = 1'b0;
    err_n    = err_q;
    dat_req  = 1'b0;
    ctrl_req = 1'b0;
    if (in_start) begin
      st_n  = PS_ADR_LO;
      err_n = 1'b0;
    end else if (in_stop) begin
      st_n = PS_IDLE;
    end else if (in_valid) begin
      unique case (st_q)
        PS_ADR_LO: begin
          addr_n  = {addr_q[15:8], in_byte};
          addr_ld = 1'b1;
          st_n    = PS_ADR_HI;
        end
        PS_ADR_HI: begin
          addr_n  = full_addr;
          addr_ld = 1'b1;
          st_n    = (full_addr == CTRL_ADDR) ? PS_CTRL : PS_ATTR;
        end
        PS_ATTR: begin
          if (in_byte[MODE_LSB+1:MODE_LSB] != 2'b00) begin
            err_n = 1'b1;
            st_n  = PS_SKIP;
          end else begin
            cc8_n   = in_byte[CC8_BIT];
            attr_n  = in_byte[ATTR_W-1:0];
            attr_ld = 1'b1;
            st_n    = PS_DATA;
          end
        end
        PS_DATA: begin
          dat_req = 1'b1;
          addr_n  = addr_q + 16'd1;
          addr_ld = 1'b1;
        end
        PS_CTRL: begin
          ctrl_req = 1'b1;
          st_n     = PS_SKIP;
        end
        default: ;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      addr_q <= '0;
      cc8_q  <= 1'b0;
      attr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      err_q <= err_n;
      if (addr_ld) addr_q <= addr_n;
      if (attr_ld) begin
        cc8_q  <= cc8_n;
        attr_q <= attr_n;
      end
    end
  end

  assign reg_addr  = addr_q;
  assign cc8       = cc8_q;
  assign attr      = attr_q;
  assign ctrl_byte = in_byte;
  assign mode_err  = err_q;

endmodule

// File: rtl/pram_clr_seq.sv
module pram_clr_seq #(
  parameter int DEPTH = 512,
  localparam int LOC_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_req,
  output logic             busy,
  output logic [LOC_W-1:0] clr_loc
);

  logic             busy_q, busy_n;
  logic [LOC_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;
  logic             go, last;

  always_comb begin
    go     = clr_req && !busy_q;
    last   = busy_q && (cnt_q == LOC_W'(DEPTH - 1));
    busy_n = go || (busy_q && !last);
    cnt_en = go || busy_q;
    cnt_n  = go ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign busy    = busy_q;
  assign clr_loc = cnt_q;

endmodule

// File: rtl/pram_wr_port.sv
module pram_wr_port #(
  parameter int LOC_W  = 9,
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_we,
  input  logic [LOC_W-1:0]  clr_loc,
  input  logic              dat_we,
  input  logic [LOC_W-1:0]  dat_loc,
  input  logic [WORD_W-1:0] dat_word,
  output logic              ram_we,
  output logic [LOC_W-1:0]  ram_addr,
  output logic [WORD_W-1:0] ram_wdata
);

  logic              we_n;
  logic [LOC_W-1:0]  addr_n;
  logic [WORD_W-1:0] word_n;

  // the clear owns the port; data is already gated off while it runs
  always_comb begin
    we_n   = clr_we || dat_we;
    addr_n = clr_we ? clr_loc : dat_loc;
    word_n = clr_we ? '0 : dat_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= we_n;
      if (we_n) begin
        ram_addr  <= addr_n;
        ram_wdata <= word_n;
      end
    end
  end

endmodule

// File: rtl/pram_autoattr_wr.sv
module pram_autoattr_wr
  import pram_pkg::*;
#(
  parameter int          DEPTH     = 512,
  parameter int          ATTR_W    = 4,
  parameter logic [15:0] RAM_BASE  = 16'h8000,
  parameter logic [15:0] CTRL_ADDR = 16'h8400,
  parameter int          CLR_BIT   = 3,
  localparam int LOC_W  = $clog2(DEPTH),
  localparam int WORD_W = 1 + BYTE_W + ATTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_start,
  input  logic              in_stop,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              ram_we,
  output logic [LOC_W-1:0]  ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic              clr_busy,
  output logic              mode_err
);

  localparam logic [16:0] RAM_END = {1'b0, RAM_BASE} + 17'(DEPTH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              dat_req, ctrl_req, cc8, in_range, dat_we, clr_start;
  logic [15:0]       reg_addr;
  logic [ATTR_W-1:0] attr;
  logic [BYTE_W-1:0] ctrl_byte;
  logic [LOC_W-1:0]  clr_loc, dat_loc;
  logic [WORD_W-1:0] dat_word;

  pram_hdr_parse #(
    .ATTR_W   (ATTR_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_parse (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_start (in_start),
    .in_stop  (in_stop),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .dat_req  (dat_req),
    .reg_addr (reg_addr),
    .cc8      (cc8),
    .attr     (attr),
    .ctrl_req (ctrl_req),
    .ctrl_byte(ctrl_byte),
    .mode_err (mode_err)
  );

  always_comb begin
    in_range  = ({1'b0, reg_addr} >= {1'b0, RAM_BASE}) && ({1'b0, reg_addr} < RAM_END);
    dat_loc   = LOC_W'(reg_addr - RAM_BASE);
    dat_word  = {cc8, in_byte, attr};
    dat_we    = dat_req && in_range && !clr_busy;
    clr_start = ctrl_req && ctrl_byte[CLR_BIT];
  end

  pram_clr_seq #(
    .DEPTH(DEPTH)
  ) u_clr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_req(clr_start),
    .busy   (clr_busy),
    .clr_loc(clr_loc)
  );

  pram_wr_port #(
    .LOC_W (LOC_W),
    .WORD_W(WORD_W)
  ) u_port (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_we   (clr_busy),
    .clr_loc  (clr_loc),
    .dat_we   (dat_we),
    .dat_loc  (dat_loc),
    .dat_word (dat_word),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .ram_wdata(ram_wdata)
  );

endmodule

// File: rtl/pram_autoattr_chk.sv
module pram_autoattr_chk #(
  parameter int DEPTH = 512,
  localparam int LOC_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_start,
  input logic             ram_we,
  input logic [LOC_W-1:0] ram_addr,
  input logic [12:0]      ram_wdata,
  input logic             clr_busy,
  input logic             mode_err
);

  logic [LOC_W:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_run_q <= '0;
    else if (clr_busy) busy_run_q <= busy_run_q + 1'b1;
    else               busy_run_q <= '0;
  end

  // R7: writes issued by the clear carry zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_busy) && ram_we) |-> (ram_wdata == '0));

  // R7: the clear walks the locations one by one
  p_clear_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_busy) && ram_we && $past(ram_we) && (ram_addr != '0))
      |-> (ram_addr == LOC_W'($past(ram_addr) + 1'b1)));

  // R7: busy never outlasts one pass over the RAM
  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> (busy_run_q < (LOC_W + 1)'(DEPTH)));

  // R6: no data write while the unsupported-mode flag is up
  p_moderr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && !$past(clr_busy)) |-> !ram_we);

  // R6: flag holds until a new transaction starts
  p_moderr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && !in_start) |=> mode_err);

endmodule

bind pram_autoattr_wr pram_autoattr_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_start (in_start),
  .ram_we   (ram_we),
  .ram_addr (ram_addr),
  .ram_wdata(ram_wdata),
  .clr_busy (clr_busy),
  .mode_err (mode_err)
);

// File: tb/sim_pram_autoattr_wr.sv
`timescale 1ns/1ps
module sim_pram_autoattr_wr;

  logic        clk, rst_n, in_start, in_stop, in_valid;
  logic [7:0]  in_byte;
  logic        ram_we, clr_busy, mode_err;
  logic [8:0]  ram_addr;
  logic [12:0] ram_wdata;

  pram_autoattr_wr u0 (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_stop(in_stop),
    .in_valid(in_valid), .in_byte(in_byte), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .clr_busy(clr_busy),
    .mode_err(mode_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [12:0] shadow  [512];
  logic [12:0] exp_mem [512];

  // bench model of the parser
  int          m_st = 0;  // 0 idle 1 lo 2 hi 3 attr 4 data 5 ctrl 6 skip
  logic [15:0] m_addr = 16'h0;
  logic        m_cc8 = 1'b0;
  logic [3:0]  m_attr = 4'h0;
  bit          clr_started;

  always @(negedge clk) if (ram_we) shadow[ram_addr] = ram_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return (a >= 16'h8000) && (a <= 16'h81FF);
  endfunction

  function automatic logic [12:0] mk_word(input logic c8, input logic [7:0] d, input logic [3:0] at);
    return {c8, d, at};
  endfunction

  task automatic txn_start();
    @(negedge clk); in_start = 1'b1;
    @(negedge clk); in_start = 1'b0;
    m_st = 1;
    chk(mode_err == 1'b0, "R6 flag cleared by start", 32'(mode_err), 0);
  endtask

  task automatic txn_stop();
    @(negedge clk); in_stop = 1'b1;
    @(negedge clk); in_stop = 1'b0;
    m_st = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit          bsy, exp_we, bad_mode;
    logic [8:0]  exp_a;
    logic [12:0] exp_d;
    exp_we = 0; bad_mode = 0; clr_started = 0; exp_a = '0; exp_d = '0;
    @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    bsy = clr_busy;
    case (m_st)
      1: begin m_addr[7:0] = b; m_st = 2; end
      2: begin m_addr[15:8] = b; m_st = (m_addr == 16'h8400) ? 5 : 3; end
      3: if (b[6:5] != 2'b00) begin bad_mode = 1; m_st = 6; end
         else begin m_cc8 = b[4]; m_attr = b[3:0]; m_st = 4; end
      4: begin
        if (!bsy && in_win(m_addr)) begin
          exp_we = 1; exp_a = 9'(m_addr - 16'h8000);
          exp_d = mk_word(m_cc8, b, m_attr);
          exp_mem[exp_a] = exp_d;
        end
        m_addr = m_addr + 16'd1;
      end
      5: begin
        if (b[3] && !bsy) begin
          clr_started = 1;
          for (int i = 0; i < 512; i++) exp_mem[i] = '0;
        end
        m_st = 6;
      end
      default: ;
    endcase
    @(negedge clk);
    in_valid = 1'b0;
    if (!bsy) begin
      if (exp_we) begin
        chk(ram_we == 1'b1, "R4 write strobe", 32'(ram_we), 1);
        chk(ram_addr == exp_a, "R2 location", 32'(ram_addr), 32'(exp_a));
        chk(ram_wdata == exp_d, "R3 merged word", 32'(ram_wdata), 32'(exp_d));
      end else begin
        chk(ram_we == 1'b0, "R5/R8/R10 no write", 32'(ram_we), 0);
      end
      if (bad_mode) chk(mode_err == 1'b1, "R6 flag set", 32'(mode_err), 1);
      if (clr_started) chk(clr_busy == 1'b1, "R7 busy rises", 32'(clr_busy), 1);
    end
  endtask

  task automatic watch_clear();
    int bad = 0;
    logic [31:0] first_got = 0, first_exp = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (!(ram_we && ram_addr == 9'(i) && ram_wdata == 13'h0)) begin
        if (bad == 0) begin first_got = {ram_we, 3'b0, 3'b0, ram_addr, 3'b0, ram_wdata}; first_exp = 32'(i); end
        bad++;
      end
    end
    chk(bad == 0, "R7 clear sequence", first_got, first_exp);
    chk(clr_busy == 1'b0, "R7 busy falls", 32'(clr_busy), 0);
  endtask

  task automatic compare_image(input string tag);
    int bad = 0;
    int where = 0;
    for (int i = 0; i < 512; i++)
      if (shadow[i] !== exp_mem[i]) begin if (bad == 0) where = i; bad++; end
    chk(bad == 0, tag, 32'(shadow[where]), 32'(exp_mem[where]));
  endtask

  initial begin
    rst_n = 1'b0; in_start = 0; in_stop = 0; in_valid = 0; in_byte = 8'h0;
    for (int i = 0; i < 512; i++) begin shadow[i] = 13'h1FFF; exp_mem[i] = 13'h1FFF; end
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(ram_we == 0 && clr_busy == 0 && mode_err == 0, "R1 in reset",
        {29'b0, ram_we, clr_busy, mode_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ram_we == 0 && clr_busy == 0 && mode_err == 0, "R1 after reset",
        {29'b0, ram_we, clr_busy, mode_err}, 0);

    // R10: byte before any start
    send_byte(8'h55);

    // R7: full clear
    txn_start(); send_byte(8'h00); send_byte(8'h84); send_byte(8'h08);
    if (clr_started) watch_clear();
    txn_stop();
    compare_image("R7 image all zero");

    // R2 R3 R4: basic merge and increment
    txn_start(); send_byte(8'h00); send_byte(8'h80); send_byte(8'h1A);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'hFE);
    txn_stop();

    // R5: run past the top of the window
    txn_start(); send_byte(8'hFE); send_byte(8'h81); send_byte(8'h03);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    txn_stop();

    // R5: start below the window and step into it
    txn_start(); send_byte(8'hFF); send_byte(8'h7F); send_byte(8'h15);
    send_byte(8'h44); send_byte(8'h45);
    txn_stop();

    // R6: unsupported mode, then recovery
    txn_start(); send_byte(8'h10); send_byte(8'h80); send_byte(8'h25);
    send_byte(8'h77); send_byte(8'h78);
    txn_start();
    send_byte(8'h10); send_byte(8'h80); send_byte(8'h42);
    send_byte(8'h99);
    txn_stop();

    // R8: control register without the clear bit
    txn_start(); send_byte(8'h00); send_byte(8'h84); send_byte(8'hF7);
    chk(clr_busy == 1'b0, "R8 no clear", 32'(clr_busy), 0);
    send_byte(8'h08); send_byte(8'h12);
    txn_stop();

    // R10: bytes after stop
    send_byte(8'h66); send_byte(8'h67);
    compare_image("R4 image after directed writes");

    // R9: data stream straddling a clear
    txn_start(); send_byte(8'h00); send_byte(8'h84); send_byte(8'h08);
    txn_stop();
    txn_start(); send_byte(8'h10); send_byte(8'h80); send_byte(8'h09);
    for (int i = 0; i < 280; i++) send_byte(8'(i * 7 + 3));
    txn_stop();
    chk(clr_busy == 1'b0, "R9 clear finished", 32'(clr_busy), 0);
    chk(shadow[16] == 13'h0, "R9 dropped byte left zero", 32'(shadow[16]), 0);
    compare_image("R9 image after overlap");

    // random transactions
    for (int t = 0; t < 150; t++) begin
      int r = int'($urandom % 8);
      int len = 1 + int'($urandom % 16);
      logic [15:0] a;
      logic [7:0]  at;
      if (r == 0)      a = 16'h81F8 + 16'($urandom % 8);
      else if (r == 1) a = 16'h8200 + 16'($urandom % 64);
      else             a = 16'h8000 + 16'($urandom % 512);
      at = 8'($urandom);
      if ($urandom % 6 != 0) at[6:5] = 2'b00;
      txn_start(); send_byte(a[7:0]); send_byte(a[15:8]); send_byte(at);
      for (int k = 0; k < len; k++) send_byte(8'($urandom));
      txn_stop();
    end
    compare_image("R4 image after random traffic");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule